// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block moves outgoing frames from host memory to a byte stream. The host builds a ring of eight-byte descriptors. Each descriptor names a buffer and its byte count, and marks it as owned by the engine. The host then pulses a demand input. The engine walks the ring from its current slot and streams every owned buffer out on a valid/ready byte interface. It pads short frames with zeros, writes a status half-word, and gives each descriptor back by clearing its owner bit. When it meets a descriptor the host still owns, it goes quiet until the next demand.

All memory traffic goes through one word-wide port, at most one access per cycle, with read data returned one cycle after the request. The ring pointer input carries both the ring's byte base and, in its top three bits, the log2 of the number of slots. The slot index therefore wraps by masking, with no divide.

Top module: `txr_engine`

## Requirements
- R1: After reset, tx_valid, mem_rd and mem_wr are low, and the engine makes no memory access until tx_demand is pulsed.
- R2: On demand the engine reads word 0 of the current slot. If bit 31 (owner) is 0, it stops with no byte sent and no memory write, and stays idle until the next demand. The slot index does not move.
- R3: Bits 23:0 of word 0 give the buffer byte address. The byte at address a sits in memory word a>>2 at bits 8*(a mod 4)+7 : 8*(a mod 4). Buffer bytes leave in ascending address order.
- R4: The byte count is the two's complement negation of bits 15:0 of word 1, taken modulo 2^16.
- R5: While tx_valid is high and tx_ready is low, tx_valid, tx_data and tx_last hold their values until the stall limit is reached.
- R6: Word 0 bit 25 marks the first descriptor of a frame and bit 24 the last. A frame may span several descriptors. tx_last is high on exactly the final byte of each frame.
- R7: A frame shorter than 60 bytes is followed by zero bytes up to 60 bytes in total, and the final pad byte carries tx_last.
- R8: After a descriptor, the engine writes word 1 first, as {status[15:0], original count field}, then word 0 with bit 31 cleared and all other bits kept. The status is zero on success.
- R9: If tx_ready stays low for STALL_LIMIT (default 16) consecutive cycles while a byte is offered, the engine abandons the descriptor. It writes status bits 15 (error) and 14 (underflow), that is word 1 bits 31 and 30, releases the descriptor and goes on to the next slot.
- R10: The ring pointer holds log2 of the slot count in bits 31:29 and the 8-byte-aligned ring base in bits 23:3. Slot i sits at base + 8*i. After the last slot the index wraps to 0.
- R11: mem_rd and mem_wr are never high in the same cycle. Read data is taken in the cycle after mem_rd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_ptr | input | 32 | Ring base (bits 23:3) and log2 slot count (bits 31:29) |
| tx_demand | input | 1 | One-cycle pulse that starts a ring walk |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | 22 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid the cycle after mem_rd |
| tx_valid | output | 1 | Output byte valid |
| tx_ready | input | 1 | Sink accepts byte |
| tx_data | output | 8 | Output byte |
| tx_last | output | 1 | Final byte of a frame |

## Verification
A wrong slot index or a bad wrap shows up at the ports straight away. The engine reads the wrong descriptor address, and the buffers then leave in the wrong order, which the stream comparison catches once the walk is done. A wrong frame counter or remaining-byte counter shows up as a misplaced tx_last or a wrong pad length within a frame. A wrong write-back or a broken stall timer shows up in the descriptor words the host reads back after each walk. The stall timer is exercised by holding the sink blocked for a whole descriptor. Random frame layouts, byte offsets and sink back-pressure are mixed with directed cases for padding, multi-descriptor frames, a non-owned slot and the ring wrap.

// File: rtl/txr_pkg.sv
package txr_pkg;
  // Descriptor word 0 bit positions
  localparam int unsigned OWN_BIT = 31;
  localparam int unsigned SOF_BIT = 25;
  localparam int unsigned EOF_BIT = 24;
  // Status half-word bit positions (upper half of word 1)
  localparam int unsigned ST_ERR_BIT = 15;
  localparam int unsigned ST_UFL_BIT = 14;

  typedef enum logic [3:0] {
    S_IDLE,
    S_RQ0,
    S_CAP0,
    S_RQ1,
    S_CAP1,
    S_FETCH,
    S_LOAD,
    S_SEND,
    S_PAD,
    S_WB1,
    S_WB0
  } walk_state_e;
endpackage

// File: rtl/txr_ring_index.sv
module txr_ring_index #(
  parameter int unsigned IDXW = 7,
  parameter int unsigned AW   = 22
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    ring_log2,
  input  logic [AW-1:0] ring_base_w,
  input  logic          adv,
  output logic [AW-1:0] desc_w0,
  output logic [AW-1:0] desc_w1
);
  logic [IDXW-1:0] mask_w;
  logic [IDXW-1:0] idx_q, idx_d;

  // Slot mask: bit g set when the ring has more than 2^g slots
  for (genvar g = 0; g < IDXW; g++) begin : g_mask
    assign mask_w[g] = (ring_log2 > 3'(g));
  end

  always_comb begin
    idx_d = idx_q;
    if (adv) idx_d = (idx_q + 1'b1) & mask_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  assign desc_w0 = ring_base_w + AW'({idx_q, 1'b0});
  assign desc_w1 = desc_w0 + 1'b1;

  // R10
  idx_in_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_q & ~mask_w) == '0);
endmodule

// File: rtl/txr_stall_timer.sv
module txr_stall_timer #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic valid,
  input  logic ready,
  output logic expired
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          stalled;

  assign stalled = valid && !ready;
  assign expired = stalled && (cnt_q == CW'(LIMIT - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (!stalled || expired) cnt_d = '0;
    else                     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R9
  stall_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(LIMIT));
endmodule

// File: rtl/txr_engine.sv
module txr_engine
  import txr_pkg::*;
#(
  parameter int unsigned BYTE_AW     = 24,
  parameter int unsigned MIN_FRAME   = 60,
  parameter int unsigned STALL_LIMIT = 16,
  localparam int unsigned AW         = BYTE_AW - 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [31:0]   ring_ptr,
  input  logic          tx_demand,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data,
  output logic          tx_last
);
  localparam int unsigned IDXW = 7;
  localparam logic [15:0] MIN16 = 16'(MIN_FRAME);

  walk_state_e state_q, state_d;
  logic [31:0]        w0_q, w0_d, w1_q, w1_d, wbuf_q, wbuf_d;
  logic [BYTE_AW-1:0] cur_q, cur_d;
  logic [15:0]        rem_q, rem_d, frm_q, frm_d, frm_inc;
  logic               err_q, err_d;
  logic               w0_en, w1_en, wbuf_en;
  logic               adv, hs, stall_to, short_after;
  logic [AW-1:0]      ring_base_w, desc_w0, desc_w1;

  assign ring_base_w = {ring_ptr[BYTE_AW-1:3], 1'b0};

  txr_ring_index #(.IDXW(IDXW), .AW(AW)) u_index (
    .clk         (clk),
    .rst_n       (rst_n),
    .ring_log2   (ring_ptr[31:29]),
    .ring_base_w (ring_base_w),
    .adv         (adv),
    .desc_w0     (desc_w0),
    .desc_w1     (desc_w1)
  );

  txr_stall_timer #(.LIMIT(STALL_LIMIT)) u_stall (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid   (tx_valid),
    .ready   (tx_ready),
    .expired (stall_to)
  );

  assign tx_valid    = (state_q == S_SEND) || (state_q == S_PAD);
  assign hs          = tx_valid && tx_ready;
  assign frm_inc     = (frm_q == 16'hFFFF) ? frm_q : frm_q + 16'd1;
  assign short_after = frm_inc < MIN16;
  assign tx_data     = (state_q == S_SEND) ? wbuf_q[8*cur_q[1:0] +: 8] : 8'h00;
  assign tx_last     = ((state_q == S_SEND) && w0_q[EOF_BIT] && (rem_q == 16'd1) && !short_after)
                    || ((state_q == S_PAD) && !short_after);

  assign w0_en   = (state_q == S_CAP0);
  assign w1_en   = (state_q == S_CAP1);
  assign wbuf_en = (state_q == S_LOAD);

  always_comb begin
    state_d   = state_q;
    w0_d      = mem_rdata;
    w1_d      = mem_rdata;
    wbuf_d    = mem_rdata;
    cur_d     = cur_q;
    rem_d     = rem_q;
    frm_d     = frm_q;
    err_d     = err_q;
    adv       = 1'b0;
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (state_q)
      S_IDLE: if (tx_demand) state_d = S_RQ0;
      S_RQ0: begin
        mem_rd   = 1'b1;
        mem_addr = desc_w0;
        state_d  = S_CAP0;
      end
      S_CAP0: state_d = mem_rdata[OWN_BIT] ? S_RQ1 : S_IDLE;
      S_RQ1: begin
        mem_rd   = 1'b1;
        mem_addr = desc_w1;
        state_d  = S_CAP1;
      end
      S_CAP1: begin
        rem_d = 16'd0 - mem_rdata[15:0];
        cur_d = w0_q[BYTE_AW-1:0];
        err_d = 1'b0;
        frm_d = w0_q[SOF_BIT] ? 16'd0 : frm_q;
        if (rem_d != 16'd0)                       state_d = S_FETCH;
        else if (w0_q[EOF_BIT] && (frm_d < MIN16)) state_d = S_PAD;
        else                                      state_d = S_WB1;
      end
      S_FETCH: begin
        mem_rd   = 1'b1;
        mem_addr = cur_q[BYTE_AW-1:2];
        state_d  = S_LOAD;
      end
      S_LOAD: state_d = S_SEND;
      S_SEND: begin
        if (hs) begin
          rem_d = rem_q - 16'd1;
          cur_d = cur_q + 1'b1;
          frm_d = frm_inc;
          if (rem_q == 16'd1)
            state_d = (w0_q[EOF_BIT] && short_after) ? S_PAD : S_WB1;
          else if (cur_q[1:0] == 2'b11)
            state_d = S_FETCH;
        end else if (stall_to) begin
          err_d   = 1'b1;
          state_d = S_WB1;
        end
      end
      S_PAD: begin
        if (hs) begin
          frm_d = frm_inc;
          if (!short_after) state_d = S_WB1;
        end else if (stall_to) begin
          err_d   = 1'b1;
          state_d = S_WB1;
        end
      end
      S_WB1: begin
        mem_wr    = 1'b1;
        mem_addr  = desc_w1;
        mem_wdata = {err_q, err_q, 14'd0, w1_q[15:0]};
        state_d   = S_WB0;
      end
      S_WB0: begin
        mem_wr    = 1'b1;
        mem_addr  = desc_w0;
        mem_wdata = {1'b0, w0_q[30:0]};
        adv       = 1'b1;
        state_d   = S_RQ0;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      w0_q    <= '0;
      w1_q    <= '0;
      wbuf_q  <= '0;
      cur_q   <= '0;
      rem_q   <= '0;
      frm_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (w0_en)   w0_q   <= w0_d;
      if (w1_en)   w1_q   <= w1_d;
      if (wbuf_en) wbuf_q <= wbuf_d;
      cur_q <= cur_d;
      rem_q <= rem_d;
      frm_q <= frm_d;
      err_q <= err_d;
    end
  end

  // R11
  one_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R5
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !stall_to) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  // R8
  own_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_WB1) |=> (mem_wr && !mem_wdata[OWN_BIT]));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE) |-> (!mem_rd && !mem_wr && !tx_valid));
endmodule

// File: tb/tb_txr_engine.sv
`timescale 1ns/1ps
module tb_txr_engine;
  localparam int STALL = 16;
  localparam int MINF  = 60;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] ring_ptr;
  logic        tx_demand;
  logic        mem_rd, mem_wr;
  logic [21:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic        tx_valid, tx_ready, tx_last;
  logic [7:0]  tx_data;

  txr_engine #(.STALL_LIMIT(STALL)) dut (
    .clk(clk), .rst_n(rst_n), .ring_ptr(ring_ptr), .tx_demand(tx_demand),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_last(tx_last)
  );

  always #10 clk = ~clk;

  logic [31:0] mem [0:4095];
  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[11:0]];
    if (mem_wr) mem[mem_addr[11:0]] <= mem_wdata;
  end

  int n_chk = 0, n_err = 0;
  int rdy_mode = 0;
  int rd_cnt = 0, wr_cnt = 0, both_cnt = 0, hold_bad = 0;
  int bench_frm = 0;
  logic [7:0] got_d[$], exp_d[$];
  bit         got_l[$], exp_l[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  // Sink ready driver
  initial begin
    tx_ready = 1'b1;
    forever begin
      @(posedge clk);
      #2;
      case (rdy_mode)
        0: tx_ready = 1'b1;
        1: tx_ready = ($urandom % 4) != 0;
        default: tx_ready = 1'b0;
      endcase
    end
  end

  // Port monitor, sampled at the falling edge
  initial begin
    bit pv = 0, pr = 0, pl = 0;
    logic [7:0] pd = 0;
    int srun = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (mem_rd) rd_cnt++;
        if (mem_wr) wr_cnt++;
        if (mem_rd && mem_wr) both_cnt++;
        if (pv && !pr && srun < STALL)
          if (!(tx_valid && tx_data == pd && tx_last == pl)) hold_bad++;
        if (tx_valid && tx_ready) begin
          got_d.push_back(tx_data);
          got_l.push_back(tx_last);
        end
        srun = (tx_valid && !tx_ready) ? srun + 1 : 0;
        pv = tx_valid; pr = tx_ready; pd = tx_data; pl = tx_last;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R1 watchdog expired: actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  function automatic int dw(input int ring_b, input int idx);
    return ring_b / 4 + 2 * idx;
  endfunction

  task automatic put_byte(input int a, input logic [7:0] b);
    mem[a >> 2][8*(a & 3) +: 8] = b;
  endtask

  // Fill buffer, build descriptor, record expected bytes when 'expect_out'
  task automatic make_desc(input int ring_b, input int idx, input int buf_b,
                           input int len, input bit sof, input bit eof, input bit expect_out);
    if (sof) bench_frm = 0;
    for (int i = 0; i < len; i++) begin
      logic [7:0] b = 8'($urandom);
      put_byte(buf_b + i, b);
      if (expect_out) begin
        exp_d.push_back(b);
        exp_l.push_back(eof && (i == len - 1) && (bench_frm + i + 1 >= MINF));
      end
    end
    bench_frm += len;
    if (eof && expect_out) begin
      while (bench_frm < MINF) begin
        bench_frm++;
        exp_d.push_back(8'h00);
        exp_l.push_back(bench_frm == MINF);
      end
    end
    mem[dw(ring_b, idx)]     = {1'b1, 5'd0, sof, eof, 24'(buf_b)};
    mem[dw(ring_b, idx) + 1] = {16'h5A5A, 16'(-len)};
  endtask

  task automatic check_desc(input string tag, input int ring_b, input int idx, input int buf_b,
                            input int len, input bit sof, input bit eof, input logic [15:0] st);
    chk(mem[dw(ring_b, idx)] == {1'b0, 5'd0, sof, eof, 24'(buf_b)}, tag, "word0 release",
        mem[dw(ring_b, idx)], {1'b0, 5'd0, sof, eof, 24'(buf_b)});
    chk(mem[dw(ring_b, idx) + 1] == {st, 16'(-len)}, tag, "word1 status",
        mem[dw(ring_b, idx) + 1], {st, 16'(-len)});
  endtask

  task automatic demand();
    @(negedge clk); tx_demand = 1'b1;
    @(negedge clk); tx_demand = 1'b0;
  endtask

  task automatic wait_done(input int ring_b, input int idx);
    int n = 0;
    while (mem[dw(ring_b, idx)][31] && n < 20000) begin
      @(negedge clk); n++;
    end
    if (n >= 20000) chk(0, "R2", "descriptor never released", 1, 0);
    repeat (30) @(negedge clk);
  endtask

  task automatic cmp_stream(input string tag);
    bit ok = (got_d.size() == exp_d.size());
    int bad = -1;
    if (ok)
      for (int i = 0; i < exp_d.size(); i++)
        if (got_d[i] != exp_d[i] || got_l[i] != exp_l[i]) begin
          ok = 0; if (bad < 0) bad = i;
        end
    chk(got_d.size() == exp_d.size(), tag, "stream length", got_d.size(), exp_d.size());
    if (got_d.size() == exp_d.size())
      chk(ok, tag, "stream content first mismatch",
          bad < 0 ? 0 : {got_d[bad], 7'd0, got_l[bad]},
          bad < 0 ? 0 : {exp_d[bad], 7'd0, exp_l[bad]});
    got_d.delete(); got_l.delete(); exp_d.delete(); exp_l.delete();
  endtask

  initial begin
    int ra, rb, eidx, nlast;
    void'($urandom(32'd4242));
    for (int i = 0; i < 4096; i++) mem[i] = 32'd0;
    rst_n = 1'b0; tx_demand = 1'b0;
    ra = 32'h100;
    ring_ptr = {3'd2, 5'd0, 24'(ra)};
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state and idle silence
    chk(!tx_valid && !mem_rd && !mem_wr, "R1", "outputs after reset",
        {tx_valid, mem_rd, mem_wr}, 0);
    rd_cnt = 0; wr_cnt = 0;
    repeat (20) @(negedge clk);
    chk(rd_cnt == 0 && wr_cnt == 0, "R1", "accesses before demand", rd_cnt + wr_cnt, 0);

    // Directed: long frame, short padded frame, two-descriptor padded frame
    make_desc(ra, 0, 32'h1001, 70, 1, 1, 1);
    make_desc(ra, 1, 32'h1101, 10, 1, 1, 1);
    make_desc(ra, 2, 32'h1202, 30, 1, 0, 1);
    make_desc(ra, 3, 32'h1303, 20, 0, 1, 1);
    wr_cnt = 0;
    demand();
    wait_done(ra, 3);
    nlast = 0;
    foreach (got_l[i]) nlast += got_l[i];
    chk(nlast == 3, "R6", "frame end markers", nlast, 3);
    cmp_stream("R4");
    check_desc("R8", ra, 0, 32'h1001, 70, 1, 1, 16'h0000);
    check_desc("R8", ra, 1, 32'h1101, 10, 1, 1, 16'h0000);
    check_desc("R8", ra, 2, 32'h1202, 30, 1, 0, 16'h0000);
    check_desc("R8", ra, 3, 32'h1303, 20, 0, 1, 16'h0000);
    chk(wr_cnt == 8, "R8", "write-back count", wr_cnt, 8);
    rd_cnt = 0; wr_cnt = 0;
    repeat (40) @(negedge clk);
    chk(rd_cnt == 0 && wr_cnt == 0, "R2", "quiet after stop", rd_cnt + wr_cnt, 0);

    // R10: index wrapped to slot 0
    make_desc(ra, 0, 32'h1400, 64, 1, 1, 1);
    make_desc(ra, 1, 32'h1480, 61, 1, 1, 1);
    demand();
    wait_done(ra, 1);
    cmp_stream("R10");
    check_desc("R10", ra, 1, 32'h1480, 61, 1, 1, 16'h0000);

    // R2: slot 2 not owned
    rd_cnt = 0; wr_cnt = 0;
    demand();
    repeat (50) @(negedge clk);
    chk(rd_cnt == 1 && wr_cnt == 0 && got_d.size() == 0, "R2", "non-owned slot activity",
        rd_cnt * 256 + wr_cnt * 16 + got_d.size(), 1 * 256);
    cmp_stream("R2");

    // R9: blocked sink, then recovery with padding
    rdy_mode = 2;
    make_desc(ra, 2, 32'h1500, 20, 1, 1, 0);
    demand();
    wait_done(ra, 2);
    check_desc("R9", ra, 2, 32'h1500, 20, 1, 1, 16'hC000);
    chk(got_d.size() == 0, "R9", "bytes accepted while blocked", got_d.size(), 0);
    rdy_mode = 1;
    make_desc(ra, 3, 32'h1581, 5, 1, 1, 1);
    demand();
    wait_done(ra, 3);
    cmp_stream("R7");
    check_desc("R9", ra, 3, 32'h1581, 5, 1, 1, 16'h0000);
    chk(hold_bad == 0, "R5", "byte changed during stall", hold_bad, 0);

    // Random rounds on an eight-slot ring
    rb = 32'h200;
    ring_ptr = {3'd3, 5'd0, 24'(rb)};
    eidx = 0;
    for (int r = 0; r < 6; r++) begin
      int k = 1 + ($urandom % 8);
      bit prev_eof = 1;
      int slots[8], bufs[8], lens[8];
      bit sofs[8], eofs[8];
      for (int j = 0; j < k; j++) begin
        slots[j] = (eidx + j) % 8;
        bufs[j]  = 32'h2000 + slots[j] * 32'h80 + ($urandom % 4);
        lens[j]  = 1 + ($urandom % 100);
        sofs[j]  = prev_eof;
        eofs[j]  = (j == k - 1) || ($urandom % 2);
        prev_eof = eofs[j];
        make_desc(rb, slots[j], bufs[j], lens[j], sofs[j], eofs[j], 1);
      end
      demand();
      wait_done(rb, slots[k-1]);
      cmp_stream("R3");
      for (int j = 0; j < k; j++)
        check_desc("R8", rb, slots[j], bufs[j], lens[j], sofs[j], eofs[j], 16'h0000);
      eidx = (eidx + k) % 8;
    end
    chk(hold_bad == 0, "R5", "byte changed during stall", hold_bad, 0);
    chk(both_cnt == 0, "R11", "read and write together", both_cnt, 0);

    summary();
    $finish;
  end
endmodule